// File: doc/BRIEF.md
# CAM Cascade Chain Controller

This block sits beside each content-addressable memory device in a vertical stack. With it, several devices behave as one deeper array. Each device holds two registers. The page register is loaded once at start-up and forms the high-order bits of any match address the device reports. The select register names the device that register and memory accesses target. An all-ones value in the select register addresses every device at once.

The devices are linked by two active-low flag chains. The match chain tells each device whether any earlier device matched. The full chain tells each device whether every earlier device is full. From these inputs each device works out for itself whether it is the single responder for a highest-priority-match operation, or the single target of a next-free operation. No external priority encoder is needed.

The first device ties its upstream match input high ("no match") and its upstream full input low ("full"). Every later device takes both inputs from the outputs of the device before it. The CAM array itself is not part of the block: it appears only as the local flag inputs and the local match address.

Top module: `cam_cascade_ctl`

## Requirements
- R1: After reset the page register is 0 and the select register is all ones, so `dev_sel` is 1.
- R2: `dev_sel` is 1 exactly when the select register equals the page register, or when the select register is all ones. A `cfg_page_we` pulse loads the page register from `cfg_data`, and a `cfg_sel_we` pulse loads the select register from `cfg_data`; each load takes effect at the next clock edge.
- R3: `dn_match_n` is 0 exactly when `loc_match` is 1 or `up_match_n` is 0.
- R4: `dn_full_n` is 0 exactly when `loc_full` is 1 and `up_full_n` is 0.
- R5: `sys_addr` equals the page register concatenated above `loc_addr`.
- R6: For a read (`rd_cyc`=1) with `op` 2'b00 (plain) or 2'b01 (hit), and for a write (`wr_cyc`=1) with `op` 2'b01, the device is enabled only when `dev_sel`=1, `loc_match`=1 and `up_match_n`=1. In a chain this is the first matching device.
- R7: For `op` 2'b10 (free), a read of the next-free register and a move-to-next-free write are enabled only when `dev_sel`=1, `loc_full`=0 and `up_full_n`=0. In a chain this is the first device that is not full.
- R8: When no device in the chain matched, no device drives the bus for a plain or hit read; a next-free register read is still served.
- R9: A write with `op` 2'b00 enables every selected device, whatever the flags.
- R10: `op` 2'b11 enables nothing. `bus_drive` and `wr_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_we | input | 1 | Load the page register from cfg_data |
| cfg_sel_we | input | 1 | Load the select register from cfg_data |
| cfg_data | input | PAGE_W | Configuration value |
| loc_match | input | 1 | Local array has a match |
| loc_full | input | 1 | Local array is full |
| loc_addr | input | LOC_AW | Local highest-priority match address |
| up_match_n | input | 1 | Upstream chain: 0 when an earlier device matched |
| up_full_n | input | 1 | Upstream chain: 0 when all earlier devices are full |
| rd_cyc | input | 1 | Read cycle |
| wr_cyc | input | 1 | Write cycle |
| op | input | 2 | 00 plain, 01 hit, 10 free, 11 reserved |
| dn_match_n | output | 1 | Downstream match chain |
| dn_full_n | output | 1 | Downstream full chain |
| dev_sel | output | 1 | Device is addressed by the select register |
| bus_drive | output | 1 | Device drives the read data bus |
| wr_en | output | 1 | Device accepts the write |
| sys_addr | output | PAGE_W+LOC_AW | System match address |

## Verification
The assertions check on every cycle the per-device rules: the chain outputs follow the local and upstream flags, a read or write is enabled only with the qualifying flags, the reserved opcode enables nothing, and read and write enables are exclusive. Some properties only hold across the whole stack, so only the bench scenarios with four chained devices can show them. These are: exactly one device answers a hit or free operation for each pattern of match and full flags; nothing answers when no device matched or all are full; and the select register narrows access to one page or widens it to all.

// File: rtl/cam_cascade_ctl.sv
module cam_cascade_ctl #(
  parameter int PAGE_W = 16,
  parameter int LOC_AW = 12,
  localparam int SYS_AW = PAGE_W + LOC_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page_we,
  input  logic              cfg_sel_we,
  input  logic [PAGE_W-1:0] cfg_data,
  input  logic              loc_match,
  input  logic              loc_full,
  input  logic [LOC_AW-1:0] loc_addr,
  input  logic              up_match_n,
  input  logic              up_full_n,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  input  logic [1:0]        op,
  output logic              dn_match_n,
  output logic              dn_full_n,
  output logic              dev_sel,
  output logic              bus_drive,
  output logic              wr_en,
  output logic [SYS_AW-1:0] sys_addr
);
  localparam logic [1:0] OP_PLAIN = 2'b00;
  localparam logic [1:0] OP_HIT   = 2'b01;
  localparam logic [1:0] OP_FREE  = 2'b10;
  localparam logic [PAGE_W-1:0] ALL_DEV = '1;

  logic [PAGE_W-1:0] page_q, sel_q;
  logic hit_owner, free_owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      sel_q  <= ALL_DEV;
    end else begin
      if (cfg_page_we) page_q <= cfg_data;
      if (cfg_sel_we)  sel_q  <= cfg_data;
    end
  end

  assign dev_sel    = (sel_q == page_q) || (sel_q == ALL_DEV);
  assign dn_match_n = up_match_n & ~loc_match;
  assign dn_full_n  = ~(loc_full & ~up_full_n);
  assign hit_owner  = loc_match & up_match_n;
  assign free_owner = ~loc_full & ~up_full_n;
  assign sys_addr   = {page_q, loc_addr};

  always_comb begin
    bus_drive = 1'b0;
    wr_en     = 1'b0;
    if (rd_cyc && !wr_cyc) begin
      unique case (op)
        OP_PLAIN, OP_HIT: bus_drive = dev_sel & hit_owner;
        OP_FREE:          bus_drive = dev_sel & free_owner;
        default:          bus_drive = 1'b0;
      endcase
    end else if (wr_cyc && !rd_cyc) begin
      unique case (op)
        OP_PLAIN: wr_en = dev_sel;
        OP_HIT:   wr_en = dev_sel & hit_owner;
        OP_FREE:  wr_en = dev_sel & free_owner;
        default:  wr_en = 1'b0;
      endcase
    end
  end
endmodule

module cam_cascade_ctl_chk #(
  parameter int PAGE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_sel_we,
  input logic [PAGE_W-1:0] cfg_data,
  input logic              loc_match,
  input logic              loc_full,
  input logic              up_match_n,
  input logic              up_full_n,
  input logic              rd_cyc,
  input logic              wr_cyc,
  input logic [1:0]        op,
  input logic              dn_match_n,
  input logic              dn_full_n,
  input logic              dev_sel,
  input logic              bus_drive,
  input logic              wr_en
);
  AST_BROADCAST_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel_we && cfg_data == '1) |=> dev_sel); // R2
  AST_MATCH_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_match || !up_match_n) == !dn_match_n); // R3
  AST_FULL_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_full && !up_full_n) == !dn_full_n); // R4
  AST_HIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_drive && op != 2'b10) || (wr_en && op == 2'b01)) |-> (dev_sel && loc_match && up_match_n)); // R6
  AST_FREE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_drive || wr_en) && op == 2'b10) |-> (dev_sel && !loc_full && !up_full_n)); // R7
  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && !rd_cyc && op == 2'b00 && dev_sel) |-> wr_en); // R9
  AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b11) |-> !(bus_drive || wr_en)); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_drive && wr_en)); // R10
endmodule

bind cam_cascade_ctl cam_cascade_ctl_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel_we(cfg_sel_we), .cfg_data(cfg_data),
  .loc_match(loc_match), .loc_full(loc_full), .up_match_n(up_match_n),
  .up_full_n(up_full_n), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .op(op),
  .dn_match_n(dn_match_n), .dn_full_n(dn_full_n), .dev_sel(dev_sel),
  .bus_drive(bus_drive), .wr_en(wr_en));

// File: tb/sim_cam_cascade_ctl.sv
module sim_cam_cascade_ctl;
  localparam int PW = 16;
  localparam int LW = 12;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [3:0] page_we = '0;
  logic sel_we = 0;
  logic [PW-1:0] cdata = '0;
  logic [3:0] lm = '0, lf = '0;
  logic [LW-1:0] la [4];
  logic rd = 0, wr = 0;
  logic [1:0] op = 2'b00;
  logic [3:0] dm, df, sel, drv, wen;
  logic [PW+LW-1:0] sa [4];
  int checks = 0, fails = 0;
  bit done = 0;

  cam_cascade_ctl u0 (.clk, .rst_n, .cfg_page_we(page_we[0]), .cfg_sel_we(sel_we), .cfg_data(cdata),
    .loc_match(lm[0]), .loc_full(lf[0]), .loc_addr(la[0]), .up_match_n(1'b1), .up_full_n(1'b0),
    .rd_cyc(rd), .wr_cyc(wr), .op, .dn_match_n(dm[0]), .dn_full_n(df[0]), .dev_sel(sel[0]),
    .bus_drive(drv[0]), .wr_en(wen[0]), .sys_addr(sa[0]));
  cam_cascade_ctl u1 (.clk, .rst_n, .cfg_page_we(page_we[1]), .cfg_sel_we(sel_we), .cfg_data(cdata),
    .loc_match(lm[1]), .loc_full(lf[1]), .loc_addr(la[1]), .up_match_n(dm[0]), .up_full_n(df[0]),
    .rd_cyc(rd), .wr_cyc(wr), .op, .dn_match_n(dm[1]), .dn_full_n(df[1]), .dev_sel(sel[1]),
    .bus_drive(drv[1]), .wr_en(wen[1]), .sys_addr(sa[1]));
  cam_cascade_ctl u2 (.clk, .rst_n, .cfg_page_we(page_we[2]), .cfg_sel_we(sel_we), .cfg_data(cdata),
    .loc_match(lm[2]), .loc_full(lf[2]), .loc_addr(la[2]), .up_match_n(dm[1]), .up_full_n(df[1]),
    .rd_cyc(rd), .wr_cyc(wr), .op, .dn_match_n(dm[2]), .dn_full_n(df[2]), .dev_sel(sel[2]),
    .bus_drive(drv[2]), .wr_en(wen[2]), .sys_addr(sa[2]));
  cam_cascade_ctl u3 (.clk, .rst_n, .cfg_page_we(page_we[3]), .cfg_sel_we(sel_we), .cfg_data(cdata),
    .loc_match(lm[3]), .loc_full(lf[3]), .loc_addr(la[3]), .up_match_n(dm[2]), .up_full_n(df[2]),
    .rd_cyc(rd), .wr_cyc(wr), .op, .dn_match_n(dm[3]), .dn_full_n(df[3]), .dev_sel(sel[3]),
    .bus_drive(drv[3]), .wr_en(wen[3]), .sys_addr(sa[3]));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] first_one(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 4'b1 << i;
    return 4'b0;
  endfunction

  function automatic logic [3:0] exp_match_n(logic [3:0] m);
    logic [3:0] r;
    logic any = 0;
    for (int i = 0; i < 4; i++) begin any = any | m[i]; r[i] = ~any; end
    return r;
  endfunction

  function automatic logic [3:0] exp_full_n(logic [3:0] f);
    logic [3:0] r;
    logic all = 1;
    for (int i = 0; i < 4; i++) begin all = all & f[i]; r[i] = ~all; end
    return r;
  endfunction

  task automatic settle(); #1; endtask

  task automatic set_sel(logic [PW-1:0] v);
    @(negedge clk); cdata = v; sel_we = 1;
    @(negedge clk); sel_we = 0;
  endtask

  task automatic t_reset();
    settle();
    check("R1 all selected after reset", {28'b0, sel}, 32'hF);
    check("R5 page zero after reset", {4'b0, sa[2]}, {4'b0, 16'h0, la[2]});
  endtask

  task automatic t_pages();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cdata = PW'(i + 1); page_we = 4'b1 << i;
    end
    @(negedge clk); page_we = '0;
    check("R2 broadcast select keeps all", {28'b0, sel}, 32'hF);
    set_sel(16'd3); settle();
    check("R2 only page 3 selected", {28'b0, sel}, 32'h4);
    set_sel(16'd9); settle();
    check("R2 no page matches", {28'b0, sel}, 32'h0);
    set_sel(16'hFFFF); settle();
    check("R2 broadcast restored", {28'b0, sel}, 32'hF);
  endtask

  task automatic t_addr();
    for (int i = 0; i < 4; i++) begin
      la[i] = LW'(12'h100 * i + 12'h0A5);
      settle();
      check("R5 system address", {4'b0, sa[i]}, {4'b0, PW'(i + 1), la[i]});
    end
  endtask

  task automatic t_match();
    logic [3:0] pats [6] = '{4'b0000, 4'b0001, 4'b0100, 4'b1010, 4'b1111, 4'b1000};
    foreach (pats[k]) begin
      @(negedge clk); lm = pats[k]; rd = 1; wr = 0; op = 2'b01; settle();
      check("R3 match chain", {28'b0, dm}, {28'b0, exp_match_n(pats[k])});
      check("R6 hit read responder", {28'b0, drv}, {28'b0, first_one(pats[k])});
      op = 2'b00; settle();
      check("R8 plain read responder or denied", {28'b0, drv}, {28'b0, first_one(pats[k])});
      rd = 0; wr = 1; op = 2'b01; settle();
      check("R6 hit write responder", {28'b0, wen}, {28'b0, first_one(pats[k])});
    end
    @(negedge clk); wr = 0; rd = 0; lm = '0;
  endtask

  task automatic t_full();
    logic [3:0] pats [6] = '{4'b0000, 4'b0001, 4'b0011, 4'b1011, 4'b0111, 4'b1111};
    foreach (pats[k]) begin
      @(negedge clk); lf = pats[k]; lm = '0; wr = 1; rd = 0; op = 2'b10; settle();
      check("R4 full chain", {28'b0, df}, {28'b0, exp_full_n(pats[k])});
      check("R7 next-free write target", {28'b0, wen}, {28'b0, first_one(~pats[k])});
      wr = 0; rd = 1; settle();
      check("R8 next-free read served without match", {28'b0, drv}, {28'b0, first_one(~pats[k])});
    end
    @(negedge clk); rd = 0; lf = '0;
  endtask

  task automatic t_plain_write();
    @(negedge clk); lm = 4'b0010; lf = 4'b1111; wr = 1; op = 2'b00; settle();
    check("R9 plain write to all", {28'b0, wen}, 32'hF);
    @(negedge clk); wr = 0;
    set_sel(16'd2);
    @(negedge clk); wr = 1; op = 2'b00; settle();
    check("R9 plain write to page 2 only", {28'b0, wen}, 32'h2);
    op = 2'b01; lm = 4'b0011; settle();
    check("R6 hit write blocked when unselected", {28'b0, wen}, 32'h1 & 32'h0);
    @(negedge clk); wr = 0; lm = '0; lf = '0;
    set_sel(16'hFFFF);
  endtask

  task automatic t_reserved();
    @(negedge clk); lm = 4'b0101; lf = 4'b0000; op = 2'b11; rd = 1; settle();
    check("R10 reserved read", {28'b0, drv}, 32'h0);
    rd = 0; wr = 1; settle();
    check("R10 reserved write", {28'b0, wen}, 32'h0);
    rd = 1; op = 2'b00; settle();
    check("R10 read and write together enable nothing", {28'b0, drv | wen}, 32'h0);
    @(negedge clk); rd = 0; wr = 0; lm = '0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) la[i] = LW'(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_pages();
    t_addr();
    t_match();
    t_full();
    t_plain_write();
    t_reserved();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule